// File: doc/BRIEF.md
# Shared-Vector Interrupt Controller

This block collects up to 31 level-sensitive interrupt lines and presents them to a processor core as one request wire and an 8-bit vector bus. Software sets an enable mask through a 32-bit word-wide register port. The mask is ANDed with the raw pending bits to give the active set.

When exactly one enabled source is active, the vector names that source. When two or more are active, the block does not rank them. It presents a single shared vector, and the interrupt handler reads the masked status register to decide which source to serve first.

The raw pending bits follow their lines and do not latch. A source therefore stops requesting as soon as its line falls. Two further inputs, an NMI line and a fault line, can only be read as status bits. The mask is the only writable register. A write to any other offset is rejected with a one-cycle error pulse.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, `irq_vector` is 0x00, `bus_err` is 0, and a read at offset 0x0 returns 0 (all sources disabled).
- R2: When exactly one bit i of (lines AND mask) is set, the next clock edge sets `irq_req` to 1 and `irq_vector` to 0x31 + i. Bit i is `irq_lines[i]`, which is external line i+1.
- R3: When two or more bits of (lines AND mask) are set, the next clock edge sets `irq_req` to 1 and `irq_vector` to 0x30.
- R4: When no bit of (lines AND mask) is set, the next clock edge sets `irq_req` to 0 and `irq_vector` to 0x00.
- R5: A read at offset 0x4 returns the raw pending bits in bits [30:0], with bit 31 reading 0. These bits are the lines sampled at the last clock edge, and a bit clears as soon as its line drops.
- R6: A write at offset 0x0 loads bits [30:0] of the write data into the mask, which reads back at offset 0x0. The new mask takes effect on the vector one edge after the write edge.
- R7: A read at offset 0x8 returns the raw pending bits ANDed with the mask.
- R8: A read at offset 0xC returns the NMI line in bit 0, and a read at offset 0x10 returns the fault line in bit 0, both as sampled at the last edge. All other bits read 0, and neither register can be written.
- R9: A write at any offset other than 0x0 raises `bus_err` for exactly one cycle after the write edge and leaves the mask unchanged.
- R10: A read at any offset other than 0x0, 0x4, 0x8, 0xC or 0x10 returns 0 and does not raise `bus_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 31 | Level-sensitive interrupt lines; bit i is line i+1 |
| nmi_in | input | 1 | NMI line, status only |
| fault_in | input | 1 | Fault line, status only |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the 32-bit register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | 8 | Interrupt vector to the core |
| bus_err | output | 1 | One-cycle pulse after an invalid write |

## Verification
A change on the interrupt lines reaches `irq_req` and `irq_vector` at the first rising edge after it. A mask write lands on the write edge and reaches the vector one edge later. The error pulse appears on the write edge and drops on the next edge.

Read data is combinational from registers that update at an edge. The bench therefore changes inputs on the falling edge, lets exactly the number of rising edges above pass, and samples on the following falling edge. This keeps each sample in a known cycle relative to the stimulus.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NUM_LINES = 31,
  parameter int ADDR_W = 5,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] SHARED_VEC = 8'h30,
  parameter logic [VEC_W-1:0] FIRST_VEC = 8'h31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [30:0]       irq_lines,
  input  logic              nmi_in,
  input  logic              fault_in,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector,
  output logic              bus_err
);
  localparam int IDX_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] mask_q, pend_q, active;
  logic                 nmi_q, fault_q;
  logic                 several, any;
  logic [IDX_W-1:0]     low_idx;
  logic [VEC_W-1:0]     vec_next;
  logic                 wr_mask, wr_bad;

  assign active  = irq_lines[NUM_LINES-1:0] & mask_q;
  assign any     = |active;
  assign several = |(active & (active - 1'b1));

  always_comb begin
    low_idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (active[i]) low_idx = IDX_W'(i);
  end

  assign vec_next = !any ? '0 : several ? SHARED_VEC : FIRST_VEC + VEC_W'(low_idx);

  assign wr_mask = bus_sel && bus_write && (bus_addr == '0);
  assign wr_bad  = bus_sel && bus_write && (bus_addr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      pend_q     <= '0;
      nmi_q      <= 1'b0;
      fault_q    <= 1'b0;
      irq_req    <= 1'b0;
      irq_vector <= '0;
      bus_err    <= 1'b0;
    end else begin
      pend_q     <= irq_lines[NUM_LINES-1:0];
      nmi_q      <= nmi_in;
      fault_q    <= fault_in;
      irq_req    <= any;
      irq_vector <= vec_next;
      bus_err    <= wr_bad;
      if (wr_mask) mask_q <= bus_wdata[NUM_LINES-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_write) begin
      case (bus_addr)
        ADDR_W'(5'h00): bus_rdata = 32'(mask_q);
        ADDR_W'(5'h04): bus_rdata = 32'(pend_q);
        ADDR_W'(5'h08): bus_rdata = 32'(pend_q & mask_q);
        ADDR_W'(5'h0C): bus_rdata = {31'b0, nmi_q};
        ADDR_W'(5'h10): bus_rdata = {31'b0, fault_q};
        default:        bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NUM_LINES = 31,
  parameter int ADDR_W = 5,
  parameter int VEC_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [30:0]          irq_lines,
  input logic [NUM_LINES-1:0] mask,
  input logic                 bus_sel,
  input logic                 bus_write,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 irq_req,
  input logic [VEC_W-1:0]     irq_vector,
  input logic                 bus_err
);
  logic [NUM_LINES-1:0] act;
  logic                 bad_wr;
  assign act    = irq_lines[NUM_LINES-1:0] & mask;
  assign bad_wr = bus_sel && bus_write && (bus_addr != '0);

  assert_single_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(act) == 1) |=> (irq_req && irq_vector >= 8'h31 && irq_vector < 8'h31 + NUM_LINES));

  assert_shared_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(act) > 1) |=> (irq_req && irq_vector == 8'h30));

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |=> (!irq_req && irq_vector == '0));

  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> bus_err);

  assert_mask_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> $stable(mask));

  assert_no_stray_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_wr |=> !bus_err);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .VEC_W(VEC_W)) chk (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .mask(mask_q),
  .bus_sel(bus_sel), .bus_write(bus_write), .bus_addr(bus_addr),
  .irq_req(irq_req), .irq_vector(irq_vector), .bus_err(bus_err)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [30:0] irq_lines = '0;
  logic        nmi_in = 1'b0, fault_in = 1'b0;
  logic        bus_sel = 1'b0, bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req;
  logic [7:0]  irq_vector;
  logic        bus_err;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .nmi_in(nmi_in), .fault_in(fault_in),
    .bus_sel(bus_sel), .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_vector(irq_vector), .bus_err(bus_err)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_vec(logic [30:0] m);
    int cnt = 0, low = 0;
    for (int i = 30; i >= 0; i--) if (m[i]) begin cnt++; low = i; end
    if (cnt == 0) return 8'h00;
    if (cnt > 1) return 8'h30;
    return 8'(8'h31 + low);
  endfunction

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic drive_and_check(string req, logic [30:0] l, logic [30:0] m);
    logic [7:0] e;
    irq_lines = l;
    tick();
    e = model_vec(l & m);
    check(req, 32'(irq_vector), 32'(e));
    check(req, 32'(irq_req), 32'(e != 8'h00));
  endtask

  initial begin
    #(5.0 * 190000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1'b1;
  end

  initial begin
    logic [31:0] d;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tick();
    check("R1 req", 32'(irq_req), 0);
    check("R1 vec", 32'(irq_vector), 0);
    check("R1 err", 32'(bus_err), 0);
    rd(5'h00, d); check("R1 mask", d, 0);

    // R4: lines active but mask zero
    drive_and_check("R4 masked off", 31'h7FFF_FFFF, 31'h0);

    // R6: enable all
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, d); check("R6 mask readback", d, 32'h7FFF_FFFF);
    check("R9 no err on valid write", 32'(bus_err), 0);

    // R2: each single source
    for (int i = 0; i < 31; i++) drive_and_check("R2 single", 31'(1) << i, 31'h7FFF_FFFF);

    // R3: pairs and triples
    for (int i = 0; i < 31; i++) begin
      drive_and_check("R3 pair", (31'(1) << i) | (31'(1) << ((i + 7) % 31)), 31'h7FFF_FFFF);
      drive_and_check("R3 triple", (31'(1) << i) | (31'(1) << ((i + 3) % 31)) | (31'(1) << ((i + 20) % 31)), 31'h7FFF_FFFF);
    end

    // R5: level behaviour and raw readback
    irq_lines = 31'h1234_5678; tick();
    rd(5'h04, d); check("R5 raw", d, 32'h1234_5678);
    irq_lines = 31'h0; tick();
    rd(5'h04, d); check("R5 cleared on drop", d, 0);
    check("R4 idle after drop", 32'(irq_req), 0);
    check("R4 idle vec", 32'(irq_vector), 0);

    // R6/R2: mask all but one restores unique vector
    irq_lines = 31'h7FFF_FFFF;
    for (int i = 0; i < 31; i += 3) begin
      wr(5'h00, 32'(1) << i);
      tick();
      check("R6 unique after mask", 32'(irq_vector), 32'h31 + i);
      rd(5'h08, d); check("R7 masked status", d, 32'(1) << i);
    end

    // R6: mask latency, vector unchanged on write edge
    wr(5'h00, 32'h0000_0005);
    check("R6 vec before effect", 32'(irq_vector), 32'h31 + 30);
    tick();
    check("R6 vec after effect", 32'(irq_vector), 32'h30);

    // R7 with partial mask
    irq_lines = 31'h0000_00F4; tick();
    rd(5'h08, d); check("R7 partial", d, 32'h4);
    check("R2 partial single", 32'(irq_vector), 32'h33);

    // R8
    nmi_in = 1'b1; fault_in = 1'b0; tick();
    rd(5'h0C, d); check("R8 nmi", d, 1);
    rd(5'h10, d); check("R8 fault low", d, 0);
    nmi_in = 1'b0; fault_in = 1'b1; tick();
    rd(5'h0C, d); check("R8 nmi low", d, 0);
    rd(5'h10, d); check("R8 fault", d, 1);

    // R9: invalid writes
    foreach (d[k]) if (k < 6) begin
      logic [4:0] a;
      a = 5'(4 * (k + 1));
      if (k == 5) a = 5'h02;
      wr(a, 32'h0000_0000);
      check("R9 err pulse", 32'(bus_err), 1);
      rd(5'h00, d); check("R9 mask kept", d, 32'h5);
      tick();
      check("R9 err drops", 32'(bus_err), 0);
    end
    rd(5'h10, d); check("R8 fault not writable", d, 1);

    // R10
    rd(5'h14, d); check("R10 unmapped 0x14", d, 0);
    rd(5'h1C, d); check("R10 unmapped 0x1C", d, 0);
    rd(5'h06, d); check("R10 unaligned", d, 0);
    tick();
    check("R10 no err on read", 32'(bus_err), 0);

    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("%0d/%0d checks passed", n_chk - n_bad + ((n_bad > n_chk) ? n_bad - n_chk : 0), n_chk > n_bad ? n_chk : n_bad);
    $finish;
  end
endmodule